// File: doc/BRIEF.md
# System-Control Cache and TLB Maintenance Decoder

This block sits beside the register-transfer port of a system-control coprocessor (number 15) and turns processor-to-coprocessor writes aimed at two maintenance registers into one-cycle command pulses. One register drives the instruction and data caches. The other drives the instruction and data translation look-aside buffers. The value written does not choose the action: any value starts it. For the single-entry data operation, the value is passed along as the virtual address.

Each transfer carries these fields:
- coprocessor number;
- direction (write to the coprocessor, or read from it);
- a primary operation code (`op_a`);
- a major register number (`reg_major`);
- a minor register number (`reg_minor`);
- a secondary operation code (`op_b`);
- a 32-bit data word.

The pair {`op_b`, `reg_minor`} picks the action. The same table applies to both maintenance registers. Some transfers land on the two maintenance registers but cannot be honoured: reads, a nonzero `op_a`, or an unlisted pair. These raise `unclaimed` so that the core can take its undefined-instruction trap.

Internally, a four-state machine registers each decoded transfer for one cycle:
- IDLE: no command.
- CACHE_OP: a cache pulse is shown.
- TLB_OP: a TLB pulse is shown.
- TRAP: `unclaimed` is shown.

Every state is entered from any state in the cycle after a transfer of the matching kind. Every state returns to IDLE when no relevant transfer is present.

Top module: `sysctl_maint_decoder`

## Requirements
- R1: After reset, every pulse output and `unclaimed` are 0 and `entry_vaddr` is 0.
- R2: A write with coprocessor 15, `op_a`=0, `reg_major`=7, `op_b`=0 and `reg_minor`=4'b0111 raises `cache_inv_i` and `cache_inv_d` together in the next cycle.
- R3: The same write with `reg_minor`=4'b0101 raises only `cache_inv_i` in the next cycle.
- R4: The same write with `reg_minor`=4'b0110 raises only `cache_inv_d` in the next cycle.
- R5: A write with `reg_major`=7, `op_b`=1 and `reg_minor`=4'b0110 raises only `cache_inv_d_entry` in the next cycle. In that same cycle, `entry_vaddr` equals the written word. In every other cycle, `entry_vaddr` is 0.
- R6: `reg_major`=8 uses the same {`op_b`, `reg_minor`} table, driving `tlb_inv_i`, `tlb_inv_d` and `tlb_inv_d_entry` in place of the cache outputs.
- R7: The written value, including all-zeros and all-ones, never changes which action is taken.
- R8: A read (`xfer_read`=1) of register 7 or 8 raises `unclaimed` in the next cycle and no pulse.
- R9: A nonzero `op_a` on register 7 or 8 raises `unclaimed` in the next cycle and no pulse.
- R10: An unlisted {`op_b`, `reg_minor`} pair on register 7 or 8 raises `unclaimed` in the next cycle and no pulse.
- R11: Transfers to another coprocessor, or to another register of coprocessor 15, produce no pulse and no `unclaimed`.
- R12: Each pulse lasts exactly one cycle unless the next cycle carries another transfer. Back-to-back transfers give pulses in consecutive cycles, and outputs drop to 0 one cycle after the transfers stop.
- R13: `unclaimed` is never high in the same cycle as any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A register transfer is offered this cycle |
| xfer_read | input | 1 | 1 = coprocessor-to-core read, 0 = core-to-coprocessor write |
| cp_sel | input | 4 | Target coprocessor number |
| op_a | input | 3 | Primary operation code |
| reg_major | input | 4 | Major coprocessor register number |
| reg_minor | input | 4 | Minor coprocessor register number |
| op_b | input | 3 | Secondary operation code |
| xfer_data | input | 32 | Written data word |
| cache_inv_i | output | 1 | Instruction-cache flush pulse |
| cache_inv_d | output | 1 | Data-cache flush pulse |
| cache_inv_d_entry | output | 1 | Single-entry data-cache flush pulse |
| tlb_inv_i | output | 1 | Instruction-TLB invalidate pulse |
| tlb_inv_d | output | 1 | Data-TLB invalidate pulse |
| tlb_inv_d_entry | output | 1 | Single-entry data-TLB invalidate pulse |
| entry_vaddr | output | 32 | Virtual address for the single-entry pulses |
| unclaimed | output | 1 | Transfer must be trapped as undefined |

## Verification
The hardest case to reach from the ports is a direct switch between non-idle states without passing through IDLE. Examples are a cache command followed at once by a TLB entry command, then a trap, with the address output changing and clearing on consecutive cycles. The bench drives such transfers on consecutive cycles. In each cycle it checks the previous transfer's result before applying the next one. A table also walks every listed encoding on both registers, plus reads, bad operation codes, unlisted pairs and foreign targets.

// File: rtl/maint_pkg.sv
package maint_pkg;

    typedef enum logic [2:0] {
        MOP_NONE,
        MOP_BOTH,
        MOP_ISIDE,
        MOP_DSIDE,
        MOP_DENTRY
    } mop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CACHE_OP,
        ST_TLB_OP,
        ST_TRAP
    } mstate_e;

    typedef struct packed {
        logic hit;     // transfer lands on a maintenance register
        logic is_tlb;  // register 8 rather than 7
        logic bad;     // must be trapped
        mop_e op;
    } dec_t;

    // pulse vector order: {inv_i, inv_d, inv_d_entry}
    function automatic logic [2:0] op_to_pulses(input mop_e op);
        logic [2:0] p;
        unique case (op)
            MOP_BOTH:   p = 3'b110;
            MOP_ISIDE:  p = 3'b100;
            MOP_DSIDE:  p = 3'b010;
            MOP_DENTRY: p = 3'b001;
            default:    p = 3'b000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/maint_cmd_decode.sv
module maint_cmd_decode
    import maint_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int OPC_W     = 3,
    parameter int CP_ID     = 15,
    parameter int CACHE_REG = 7,
    parameter int TLB_REG   = 8
) (
    input  logic             xfer_valid,
    input  logic             xfer_read,
    input  logic [SEL_W-1:0] cp_sel,
    input  logic [OPC_W-1:0] op_a,
    input  logic [SEL_W-1:0] reg_major,
    input  logic [SEL_W-1:0] reg_minor,
    input  logic [OPC_W-1:0] op_b,
    output dec_t             dec
);

    localparam logic [SEL_W-1:0] CP_V    = SEL_W'(CP_ID);
    localparam logic [SEL_W-1:0] CACHE_V = SEL_W'(CACHE_REG);
    localparam logic [SEL_W-1:0] TLB_V   = SEL_W'(TLB_REG);

    mop_e table_op;

    always_comb begin
        unique case ({op_b, reg_minor})
            {OPC_W'(0), SEL_W'(4'b0111)}: table_op = MOP_BOTH;
            {OPC_W'(0), SEL_W'(4'b0101)}: table_op = MOP_ISIDE;
            {OPC_W'(0), SEL_W'(4'b0110)}: table_op = MOP_DSIDE;
            {OPC_W'(1), SEL_W'(4'b0110)}: table_op = MOP_DENTRY;
            default:                      table_op = MOP_NONE;
        endcase
    end

    always_comb begin
        dec.hit    = xfer_valid && (cp_sel == CP_V) &&
                     ((reg_major == CACHE_V) || (reg_major == TLB_V));
        dec.is_tlb = (reg_major == TLB_V);
        dec.bad    = xfer_read || (op_a != '0) || (table_op == MOP_NONE);
        dec.op     = dec.bad ? MOP_NONE : table_op;
    end

endmodule

// File: rtl/maint_fsm.sv
module maint_fsm
    import maint_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] wdata,
    output mstate_e           state,
    output mop_e              op_q,
    output logic [ADDR_W-1:0] addr_q
);

    mstate_e           state_d;
    mop_e              op_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        state_d = ST_IDLE;
        op_d    = MOP_NONE;
        addr_d  = '0;
        if (dec.hit) begin
            if (dec.bad) begin
                state_d = ST_TRAP;
            end else begin
                state_d = dec.is_tlb ? ST_TLB_OP : ST_CACHE_OP;
                op_d    = dec.op;
                if (dec.op == MOP_DENTRY) begin
                    addr_d = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= MOP_NONE;
            addr_q <= '0;
        end else begin
            state  <= state_d;
            op_q   <= op_d;
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/sysctl_maint_decoder.sv
module sysctl_maint_decoder
    import maint_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 4,
    parameter int OPC_W     = 3,
    parameter int CP_ID     = 15,
    parameter int CACHE_REG = 7,
    parameter int TLB_REG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic              xfer_read,
    input  logic [SEL_W-1:0]  cp_sel,
    input  logic [OPC_W-1:0]  op_a,
    input  logic [SEL_W-1:0]  reg_major,
    input  logic [SEL_W-1:0]  reg_minor,
    input  logic [OPC_W-1:0]  op_b,
    input  logic [ADDR_W-1:0] xfer_data,
    output logic              cache_inv_i,
    output logic              cache_inv_d,
    output logic              cache_inv_d_entry,
    output logic              tlb_inv_i,
    output logic              tlb_inv_d,
    output logic              tlb_inv_d_entry,
    output logic [ADDR_W-1:0] entry_vaddr,
    output logic              unclaimed
);

    localparam int N_TGT = 2;  // 0 = caches, 1 = TLBs

    dec_t              dec;
    mstate_e           state;
    mop_e              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        pulses [N_TGT];

    maint_cmd_decode #(
        .SEL_W(SEL_W), .OPC_W(OPC_W), .CP_ID(CP_ID),
        .CACHE_REG(CACHE_REG), .TLB_REG(TLB_REG)
    ) u_decode (
        .xfer_valid(xfer_valid),
        .xfer_read (xfer_read),
        .cp_sel    (cp_sel),
        .op_a      (op_a),
        .reg_major (reg_major),
        .reg_minor (reg_minor),
        .op_b      (op_b),
        .dec       (dec)
    );

    maint_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .wdata (xfer_data),
        .state (state),
        .op_q  (op_q),
        .addr_q(addr_q)
    );

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        localparam mstate_e OWN_ST = (g == 0) ? ST_CACHE_OP : ST_TLB_OP;
        always_comb begin
            pulses[g] = (state == OWN_ST) ? op_to_pulses(op_q) : 3'b000;
        end
    end

    always_comb begin
        {cache_inv_i, cache_inv_d, cache_inv_d_entry} = pulses[0];
        {tlb_inv_i,   tlb_inv_d,   tlb_inv_d_entry}   = pulses[1];
        unclaimed   = (state == ST_TRAP);
        entry_vaddr = addr_q;
    end

endmodule

// File: rtl/sysctl_maint_checker.sv
module sysctl_maint_checker #(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 4,
    parameter int OPC_W     = 3,
    parameter int CP_ID     = 15,
    parameter int CACHE_REG = 7,
    parameter int TLB_REG   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_valid,
    input logic              xfer_read,
    input logic [SEL_W-1:0]  cp_sel,
    input logic [OPC_W-1:0]  op_a,
    input logic [SEL_W-1:0]  reg_major,
    input logic [SEL_W-1:0]  reg_minor,
    input logic [OPC_W-1:0]  op_b,
    input logic [ADDR_W-1:0] xfer_data,
    input logic              cache_inv_i,
    input logic              cache_inv_d,
    input logic              cache_inv_d_entry,
    input logic              tlb_inv_i,
    input logic              tlb_inv_d,
    input logic              tlb_inv_d_entry,
    input logic [ADDR_W-1:0] entry_vaddr,
    input logic              unclaimed
);

    logic any_pulse, entry_pulse, on_maint, any_out;
    assign any_pulse   = cache_inv_i | cache_inv_d | cache_inv_d_entry |
                         tlb_inv_i | tlb_inv_d | tlb_inv_d_entry;
    assign entry_pulse = cache_inv_d_entry | tlb_inv_d_entry;
    assign any_out     = any_pulse | unclaimed;
    assign on_maint    = xfer_valid && (cp_sel == SEL_W'(CP_ID)) &&
                         ((reg_major == SEL_W'(CACHE_REG)) ||
                          (reg_major == SEL_W'(TLB_REG)));

    // R13
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unclaimed && any_pulse));

    // R5
    vaddr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (entry_vaddr == $past(xfer_data)));

    // R5
    vaddr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_pulse |-> (entry_vaddr == '0));

    // R12
    needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> $past(on_maint));

    // R8
    read_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_maint && xfer_read) |=> unclaimed);

    // R9
    opa_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_maint && (op_a != '0)) |=> unclaimed);

    // R11
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_maint) |=> !any_out);

    // R2
    both_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_maint && !xfer_read && op_a == '0 && op_b == '0 &&
         reg_minor == SEL_W'(4'b0111) && reg_major == SEL_W'(CACHE_REG))
        |=> (cache_inv_i && cache_inv_d && !cache_inv_d_entry));

endmodule

bind sysctl_maint_decoder sysctl_maint_checker #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OPC_W(OPC_W), .CP_ID(CP_ID),
    .CACHE_REG(CACHE_REG), .TLB_REG(TLB_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_read(xfer_read),
    .cp_sel(cp_sel), .op_a(op_a), .reg_major(reg_major), .reg_minor(reg_minor),
    .op_b(op_b), .xfer_data(xfer_data), .cache_inv_i(cache_inv_i),
    .cache_inv_d(cache_inv_d), .cache_inv_d_entry(cache_inv_d_entry),
    .tlb_inv_i(tlb_inv_i), .tlb_inv_d(tlb_inv_d),
    .tlb_inv_d_entry(tlb_inv_d_entry), .entry_vaddr(entry_vaddr),
    .unclaimed(unclaimed)
);

// File: tb/test_sysctl_maint_decoder.sv
module test_sysctl_maint_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic        xfer_read = 1'b0;
    logic [3:0]  cp_sel = '0;
    logic [2:0]  op_a = '0;
    logic [3:0]  reg_major = '0;
    logic [3:0]  reg_minor = '0;
    logic [2:0]  op_b = '0;
    logic [31:0] xfer_data = '0;
    logic        cache_inv_i, cache_inv_d, cache_inv_d_entry;
    logic        tlb_inv_i, tlb_inv_d, tlb_inv_d_entry;
    logic [31:0] entry_vaddr;
    logic        unclaimed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sysctl_maint_decoder i_sysctl_maint_decoder (.*);

    // vector: {tag(4), read, cp(4), op_a(3), major(4), minor(4), op_b(3), data(32), exp(7)}
    // exp bits: {unclaimed, c_i, c_d, c_e, t_i, t_d, t_e}
    localparam int NV = 16;
    localparam logic [61:0] VEC [NV] = '{
        {4'd2,  1'b0, 4'd15, 3'd0, 4'd7, 4'b0111, 3'd0, 32'h0000_0000, 7'b0110000},
        {4'd3,  1'b0, 4'd15, 3'd0, 4'd7, 4'b0101, 3'd0, 32'h5A5A_5A5A, 7'b0100000},
        {4'd4,  1'b0, 4'd15, 3'd0, 4'd7, 4'b0110, 3'd0, 32'h0000_0010, 7'b0010000},
        {4'd5,  1'b0, 4'd15, 3'd0, 4'd7, 4'b0110, 3'd1, 32'h8000_1234, 7'b0001000},
        {4'd6,  1'b0, 4'd15, 3'd0, 4'd8, 4'b0111, 3'd0, 32'h0000_0001, 7'b0000110},
        {4'd6,  1'b0, 4'd15, 3'd0, 4'd8, 4'b0101, 3'd0, 32'h0000_0000, 7'b0000100},
        {4'd6,  1'b0, 4'd15, 3'd0, 4'd8, 4'b0110, 3'd0, 32'hDEAD_BEEF, 7'b0000010},
        {4'd6,  1'b0, 4'd15, 3'd0, 4'd8, 4'b0110, 3'd1, 32'hFFFF_F000, 7'b0000001},
        {4'd7,  1'b0, 4'd15, 3'd0, 4'd7, 4'b0111, 3'd0, 32'hFFFF_FFFF, 7'b0110000},
        {4'd8,  1'b1, 4'd15, 3'd0, 4'd7, 4'b0111, 3'd0, 32'h0000_0000, 7'b1000000},
        {4'd8,  1'b1, 4'd15, 3'd0, 4'd8, 4'b0110, 3'd1, 32'h1234_5678, 7'b1000000},
        {4'd9,  1'b0, 4'd15, 3'd1, 4'd7, 4'b0111, 3'd0, 32'h0000_0000, 7'b1000000},
        {4'd10, 1'b0, 4'd15, 3'd0, 4'd7, 4'b0111, 3'd1, 32'h0000_0000, 7'b1000000},
        {4'd10, 1'b0, 4'd15, 3'd0, 4'd8, 4'b0000, 3'd0, 32'h0000_0000, 7'b1000000},
        {4'd11, 1'b0, 4'd14, 3'd0, 4'd7, 4'b0111, 3'd0, 32'h0000_0000, 7'b0000000},
        {4'd11, 1'b0, 4'd15, 3'd0, 4'd9, 4'b0111, 3'd0, 32'h0000_0000, 7'b0000000}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [38:0] observed();
        return {unclaimed, cache_inv_i, cache_inv_d, cache_inv_d_entry,
                tlb_inv_i, tlb_inv_d, tlb_inv_d_entry, entry_vaddr};
    endfunction

    task automatic check(input string tag, input logic [38:0] exp);
        logic [38:0] act;
        act = observed();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic [3:0] cp, input logic [2:0] oa,
                         input logic [3:0] mj, input logic [3:0] mn,
                         input logic [2:0] ob, input logic [31:0] d);
        xfer_valid = 1'b1; xfer_read = rd; cp_sel = cp; op_a = oa;
        reg_major = mj; reg_minor = mn; op_b = ob; xfer_data = d;
    endtask

    task automatic idle();
        xfer_valid = 1'b0; xfer_read = 1'b0; xfer_data = 32'hA5A5_0000;
    endtask

    function automatic logic [38:0] expect_of(input logic [6:0] e, input logic [31:0] d);
        return {e, (e[3] | e[0]) ? d : 32'h0};
    endfunction

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 39'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 39'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [61:0] v;
            v = VEC[i];
            drive(v[57], v[56:53], v[52:50], v[49:46], v[45:42], v[41:39], v[38:7]);
            @(negedge clk);
            idle();
            check(tag_name(v[61:58]), expect_of(v[6:0], v[38:7]));
            @(negedge clk);
            check("R12", 39'h0);  // pulse gone after one cycle
        end

        // R12 / R13 / R5: back-to-back across states without idle
        drive(1'b0, 4'd15, 3'd0, 4'd7, 4'b0111, 3'd0, 32'h0);
        @(negedge clk);
        check("R12", expect_of(7'b0110000, 32'h0));
        drive(1'b0, 4'd15, 3'd0, 4'd8, 4'b0110, 3'd1, 32'hCAFE_0040);
        @(negedge clk);
        check("R12", expect_of(7'b0000001, 32'hCAFE_0040));
        drive(1'b0, 4'd15, 3'd0, 4'd7, 4'b0110, 3'd1, 32'h0BAD_0080);
        @(negedge clk);
        check("R5", expect_of(7'b0001000, 32'h0BAD_0080));
        drive(1'b1, 4'd15, 3'd0, 4'd8, 4'b0110, 3'd1, 32'h7777_7777);
        @(negedge clk);
        check("R13", expect_of(7'b1000000, 32'h0));
        drive(1'b0, 4'd15, 3'd0, 4'd8, 4'b0101, 3'd0, 32'h0);
        @(negedge clk);
        check("R13", expect_of(7'b0000100, 32'h0));
        idle();
        @(negedge clk);
        check("R12", 39'h0);

        // R1: reset in the middle of a command clears the outputs
        drive(1'b0, 4'd15, 3'd0, 4'd7, 4'b0110, 3'd1, 32'h1111_2222);
        rst_n = 1'b0;
        @(negedge clk);
        idle();
        check("R1", 39'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 39'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule